// File: doc/BRIEF.md
# Dual-Slot Common Interface Module Controller

This block sits between a host register port and two common-interface conditional-access module slots. The host sees six byte-wide registers. With them it sets a byte address on the card bus, picks the slot and the address space, and then runs a single-byte read or write on the card by touching the data register. The controller keeps the card strobe asserted for a configurable minimum number of cycles. It then holds the strobe until the selected slot reports ready, and only after that does it acknowledge the host.

The same control byte starts a timed reset of either slot. The reset bit clears itself once the pulse has ended and the card is ready again. The control byte also routes each slot's transport stream through its module and shows, active-low, whether a card is inserted. A presence change raises an interrupt flag when the interrupt is enabled. The host clears the flag by reading the interrupt register. A second control register drives the two transport-stream output enables and the two active-low tuner resets.

Every host transaction is a one-cycle `hostReq` pulse, accepted only while `hostBusy` is low, and is answered by a one-cycle `hostAck`. On a read, `hostRdata` is valid during that acknowledge.

Top module: `ci_dual_slot_ctrl`

## Requirements
- R1: After reset the register at offset 1 reads 0x0C, the registers at offsets 0, 2 and 3 read 0, `camRst`, `tsOutEn` and `tsRouteEn` are 0, `tunerRstN` is 2'b11, `irqOut` and `hostBusy` are 0, and both chip enables and both strobes are high.
- R2: Offset 2 keeps written bits 7:1 and reads bit 0 as 0. Offset 3 keeps written bits 6:0 and reads bit 7 as 0. `camAddr` equals {offset3[6:0], offset2[7:1], 1'b0}.
- R3: During a card access only `camCeN[sel]` is low, where sel is bit 7 of the bus control register at offset 5. `camIoSel` equals bit 6 of that register (1 selects I/O control space, 0 selects attribute memory).
- R4: A write to the data register at offset 4 drives `camDataOut` with the written byte, with `camDataOe` high and `camWrN` low. With ready already high, the strobe stays low for exactly STROBE_CYC+1 clock cycles.
- R5: A read of offset 4 pulls `camRdN` low and returns, in `hostRdata`, the `camDataIn` value sampled in the cycle where the selected slot's `camRdy` is high.
- R6: Writing 1 to bus-control bit 5 (slot 0) or bit 4 (slot 1) drives `camRst` of that slot high for exactly RST_CYC cycles. The bit reads 1 until the pulse has ended and that slot's `camRdy` is high, then reads 0. Writing 0 while the reset runs does not stop it.
- R7: Bus-control bit 3 drives `tsRouteEn[0]` and bit 2 drives `tsRouteEn[1]`.
- R8: Bus-control bit 1 reads `camDetN[0]` and bit 0 reads `camDetN[1]`, one clock after the input changes.
- R9: Offset 0 bit 0 enables the interrupt. A change of `camDetN` while it is enabled sets the pending flag, which is readable as offset 0 bit 1 and driven on `irqOut`. A read of offset 0 returns the flag and clears it. A change while disabled leaves the flag at 0.
- R10: At offset 1, bit 4 drives `tsOutEn[0]`, bit 5 drives `tsOutEn[1]`, bit 2 drives `tunerRstN[0]` and bit 3 drives `tunerRstN[1]`. The other bits read 0.
- R11: `hostBusy` stays high from an accepted request until its one-cycle `hostAck`. A request made while busy is ignored. Offsets 6 and 7 read 0 and ignore writes.
- R12: While the selected slot's `camRdy` is low after the minimum strobe time, the strobe stays low and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | One-cycle request pulse |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 3 | Register offset |
| hostWdata | input | 8 | Write byte |
| hostRdata | output | 8 | Read byte, valid with hostAck |
| hostAck | output | 1 | Transaction finished |
| hostBusy | output | 1 | Request in progress |
| irqOut | output | 1 | Pending presence interrupt |
| camAddr | output | 15 | Card byte address |
| camDataOut | output | 8 | Card write data |
| camDataOe | output | 1 | Card data bus driven |
| camDataIn | input | 8 | Card read data |
| camCeN | output | 2 | Per-slot chip enable, active low |
| camRdN | output | 1 | Read strobe, active low |
| camWrN | output | 1 | Write strobe, active low |
| camIoSel | output | 1 | 1 = I/O control space |
| camRdy | input | 2 | Per-slot ready |
| camDetN | input | 2 | Per-slot card detect, active low |
| camRst | output | 2 | Per-slot reset, active high |
| tsRouteEn | output | 2 | Stream routed through slot module |
| tsOutEn | output | 2 | Stream output enables |
| tunerRstN | output | 2 | Tuner resets, active low |

## Verification
The bench builds the block with STROBE_CYC = 3 and RST_CYC = 20. With these values the exact strobe length (four low cycles) and the exact reset pulse length can be counted cycle by cycle. A short pulse also leaves room to overlap a reset with a bus-control write and with a late card ready. Holding ready low past the minimum strobe time exposes the wait, and a request issued during it exposes the busy lockout.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int REG_AW = 3;
  localparam int NSLOT = 2;

  localparam logic [REG_AW-1:0] REG_IRQ   = 3'd0;
  localparam logic [REG_AW-1:0] REG_CTRL2 = 3'd1;
  localparam logic [REG_AW-1:0] REG_ALO   = 3'd2;
  localparam logic [REG_AW-1:0] REG_AHI   = 3'd3;
  localparam logic [REG_AW-1:0] REG_DATA  = 3'd4;
  localparam logic [REG_AW-1:0] REG_BUS   = 3'd5;

  // bus control bit positions; per-slot fields sit at base - slot
  localparam int BUS_SLOT = 7;
  localparam int BUS_IO   = 6;
  localparam int BUS_RST  = 5;
  localparam int BUS_TS   = 3;
  localparam int BUS_DET  = 1;
  // second control register; per-slot fields sit at base + slot
  localparam int C2_TSOUT = 4;
  localparam int C2_TUNER = 2;

  typedef struct packed {
    logic             regWr;
    logic             regRd;
    logic             accStart;
    logic             accCap;
    logic [NSLOT-1:0] rstClr;
  } ctrlStrb_t;

  typedef enum logic [1:0] {H_IDLE, H_STROBE, H_WAIT, H_ACK} hostSt_t;
endpackage

// File: rtl/ci_regs.sv
module ci_regs
  import ci_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  input  logic [7:0]        camDataIn,
  input  logic [NSLOT-1:0]  camDetN,
  output logic [7:0]        rdataQ,
  output logic [14:0]       camAddr,
  output logic [7:0]        camDataOut,
  output logic              slotSel,
  output logic              ioSel,
  output logic [NSLOT-1:0]  rstStart,
  output logic [NSLOT-1:0]  tsRouteEn,
  output logic [NSLOT-1:0]  tsOutEn,
  output logic [NSLOT-1:0]  tunerRstN,
  output logic              irqOut
);
  logic [6:0]       addrLo, addrHi;
  logic [NSLOT-1:0] rstBit, presReg;
  logic             irqEn, irqPend;
  logic [7:0]       wrData, busVal, ctrl2Val, muxVal;
  logic             presChg;

  assign presChg    = (presReg != camDetN);
  assign camAddr    = {addrHi, addrLo, 1'b0};
  assign camDataOut = wrData;
  assign irqOut     = irqPend;

  for (genvar s = 0; s < NSLOT; s++) begin : g_start
    assign rstStart[s] = strb.regWr && (hostAddr == REG_BUS)
                         && hostWdata[BUS_RST-s] && !rstBit[s];
  end

  always_comb begin
    busVal = '0;
    busVal[BUS_SLOT] = slotSel;
    busVal[BUS_IO]   = ioSel;
    ctrl2Val = '0;
    for (int s = 0; s < NSLOT; s++) begin
      busVal[BUS_RST-s]     = rstBit[s];
      busVal[BUS_TS-s]      = tsRouteEn[s];
      busVal[BUS_DET-s]     = presReg[s];
      ctrl2Val[C2_TSOUT+s]  = tsOutEn[s];
      ctrl2Val[C2_TUNER+s]  = tunerRstN[s];
    end
    case (hostAddr)
      REG_IRQ:   muxVal = {6'b0, irqPend, irqEn};
      REG_CTRL2: muxVal = ctrl2Val;
      REG_ALO:   muxVal = {addrLo, 1'b0};
      REG_AHI:   muxVal = {1'b0, addrHi};
      REG_BUS:   muxVal = busVal;
      default:   muxVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo <= '0; addrHi <= '0; slotSel <= 1'b0; ioSel <= 1'b0;
      rstBit <= '0; tsRouteEn <= '0; tsOutEn <= '0; tunerRstN <= '1;
      presReg <= '1; irqEn <= 1'b0; irqPend <= 1'b0;
      wrData <= '0; rdataQ <= '0;
    end else begin
      presReg <= camDetN;
      if (strb.regWr) begin
        case (hostAddr)
          REG_IRQ:   irqEn <= hostWdata[0];
          REG_ALO:   addrLo <= hostWdata[7:1];
          REG_AHI:   addrHi <= hostWdata[6:0];
          REG_CTRL2:
            for (int s = 0; s < NSLOT; s++) begin
              tsOutEn[s]   <= hostWdata[C2_TSOUT+s];
              tunerRstN[s] <= hostWdata[C2_TUNER+s];
            end
          REG_BUS: begin
            slotSel <= hostWdata[BUS_SLOT];
            ioSel   <= hostWdata[BUS_IO];
            for (int s = 0; s < NSLOT; s++) tsRouteEn[s] <= hostWdata[BUS_TS-s];
          end
          default: ;
        endcase
      end
      for (int s = 0; s < NSLOT; s++) begin
        if (rstStart[s])          rstBit[s] <= 1'b1;
        else if (strb.rstClr[s])  rstBit[s] <= 1'b0;
      end
      if (strb.accStart) wrData <= hostWdata;
      if (presChg && irqEn) irqPend <= 1'b1;
      else if (strb.regRd && hostAddr == REG_IRQ) irqPend <= 1'b0;
      if (strb.regRd)       rdataQ <= muxVal;
      else if (strb.accCap) rdataQ <= camDataIn;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    // R6
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.rstClr[s] |-> rstBit[s]);
  end

  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> $past(irqEn));
endmodule

// File: rtl/ci_ctrl.sv
module ci_ctrl
  import ci_pkg::*;
#(
  parameter int STROBE_CYC = 4,
  parameter int RST_CYC    = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic              slotSel,
  input  logic              ioSel,
  input  logic [NSLOT-1:0]  camRdy,
  input  logic [NSLOT-1:0]  rstStart,
  output ctrlStrb_t         strb,
  output logic              hostAck,
  output logic              hostBusy,
  output logic [NSLOT-1:0]  camCeN,
  output logic              camRdN,
  output logic              camWrN,
  output logic              camIoSel,
  output logic              camDataOe,
  output logic [NSLOT-1:0]  camRst
);
  localparam int SCW = $clog2(STROBE_CYC + 1);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam logic [1:0] R_IDLE = 2'd0, R_PULSE = 2'd1, R_WAIT = 2'd2;

  hostSt_t          st;
  logic [SCW-1:0]   sCnt;
  logic             weQ, onBus, isData;
  logic [NSLOT-1:0] rstClrV;

  assign isData   = (hostAddr == REG_DATA);
  assign onBus    = (st == H_STROBE) || (st == H_WAIT);
  assign hostAck  = (st == H_ACK);
  assign hostBusy = (st != H_IDLE);
  assign camCeN   = onBus ? ~(NSLOT'(1) << slotSel) : '1;
  assign camRdN   = !(onBus && !weQ);
  assign camWrN   = !(onBus && weQ);
  assign camDataOe = onBus && weQ;
  assign camIoSel = ioSel;

  always_comb begin
    strb.regWr    = (st == H_IDLE) && hostReq && hostWe && !isData;
    strb.regRd    = (st == H_IDLE) && hostReq && !hostWe && !isData;
    strb.accStart = (st == H_IDLE) && hostReq && isData;
    strb.accCap   = (st == H_WAIT) && camRdy[slotSel] && !weQ;
    strb.rstClr   = rstClrV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= H_IDLE; sCnt <= '0; weQ <= 1'b0;
    end else begin
      case (st)
        H_IDLE:
          if (hostReq) begin
            weQ <= hostWe;
            if (isData) begin
              st   <= H_STROBE;
              sCnt <= SCW'(STROBE_CYC - 1);
            end else st <= H_ACK;
          end
        H_STROBE:
          if (sCnt == '0) st <= H_WAIT;
          else sCnt <= sCnt - 1'b1;
        H_WAIT:  if (camRdy[slotSel]) st <= H_ACK;
        default: st <= H_IDLE;
      endcase
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_rst
    logic [1:0]     ph;
    logic [RCW-1:0] rCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ph <= R_IDLE; rCnt <= '0;
      end else begin
        case (ph)
          R_IDLE:
            if (rstStart[s]) begin
              ph   <= R_PULSE;
              rCnt <= RCW'(RST_CYC - 1);
            end
          R_PULSE:
            if (rCnt == '0) ph <= R_WAIT;
            else rCnt <= rCnt - 1'b1;
          R_WAIT:  if (camRdy[s]) ph <= R_IDLE;
          default: ph <= R_IDLE;
        endcase
      end
    end
    assign camRst[s]  = (ph == R_PULSE);
    assign rstClrV[s] = (ph == R_WAIT) && camRdy[s];
  end

  // R3
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~camCeN) <= 1);
  // R4
  strobe_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!camRdN || !camWrN) |-> (camCeN != '1));
  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);
  // R12
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == H_WAIT && !camRdy[slotSel]) |=> (st == H_WAIT));
endmodule

// File: rtl/ci_dual_slot_ctrl.sv
module ci_dual_slot_ctrl
  import ci_pkg::*;
#(
  parameter int STROBE_CYC = 4,
  parameter int RST_CYC    = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  logic        hostWe,
  input  logic [2:0]  hostAddr,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  output logic        hostAck,
  output logic        hostBusy,
  output logic        irqOut,
  output logic [14:0] camAddr,
  output logic [7:0]  camDataOut,
  output logic        camDataOe,
  input  logic [7:0]  camDataIn,
  output logic [1:0]  camCeN,
  output logic        camRdN,
  output logic        camWrN,
  output logic        camIoSel,
  input  logic [1:0]  camRdy,
  input  logic [1:0]  camDetN,
  output logic [1:0]  camRst,
  output logic [1:0]  tsRouteEn,
  output logic [1:0]  tsOutEn,
  output logic [1:0]  tunerRstN
);
  ctrlStrb_t  strb;
  logic       slotSel, ioSel;
  logic [1:0] rstStart;

  ci_regs u_regs (
    .clk, .rstN, .strb, .hostAddr, .hostWdata, .camDataIn, .camDetN,
    .rdataQ(hostRdata), .camAddr, .camDataOut, .slotSel, .ioSel,
    .rstStart, .tsRouteEn, .tsOutEn, .tunerRstN, .irqOut
  );

  ci_ctrl #(.STROBE_CYC(STROBE_CYC), .RST_CYC(RST_CYC)) u_ctrl (
    .clk, .rstN, .hostReq, .hostWe, .hostAddr, .slotSel, .ioSel, .camRdy,
    .rstStart, .strb, .hostAck, .hostBusy, .camCeN, .camRdN, .camWrN,
    .camIoSel, .camDataOe, .camRst
  );
endmodule

// File: tb/sim_ci_dual_slot_ctrl.sv
module sim_ci_dual_slot_ctrl;
  localparam int SC = 3;
  localparam int RC = 20;
  localparam int NV = 19;

  logic clk = 0, rstN = 0;
  logic hostReq = 0, hostWe = 0;
  logic [2:0] hostAddr = 0;
  logic [7:0] hostWdata = 0, hostRdata, camDataOut, camDataIn = 0;
  logic hostAck, hostBusy, irqOut, camDataOe, camRdN, camWrN, camIoSel;
  logic [14:0] camAddr;
  logic [1:0] camCeN, camRst, tsRouteEn, tsOutEn, tunerRstN;
  logic [1:0] camRdy = 2'b11, camDetN = 2'b11;

  int checks = 0, fails = 0, cyc = 0;
  int lowCnt = 0, rst0Cnt = 0, rst1Cnt = 0;
  logic [1:0] seenCe; logic seenIo, seenOe; logic [14:0] seenAddr; logic [7:0] seenDout;
  logic [7:0] q;

  always #4 clk = ~clk;

  ci_dual_slot_ctrl #(.STROBE_CYC(SC), .RST_CYC(RC)) u0 (.*);

  // {we, addr, wdata, expected read, requirement number}
  localparam logic [23:0] VEC [0:NV-1] = '{
    {1'b1, 3'd2, 8'hFF, 8'h00, 4'd2}, {1'b0, 3'd2, 8'h00, 8'hFE, 4'd2},
    {1'b1, 3'd3, 8'hFF, 8'h00, 4'd2}, {1'b0, 3'd3, 8'h00, 8'h7F, 4'd2},
    {1'b1, 3'd1, 8'hFF, 8'h00, 4'd10}, {1'b0, 3'd1, 8'h00, 8'h3C, 4'd10},
    {1'b1, 3'd1, 8'h00, 8'h00, 4'd10}, {1'b0, 3'd1, 8'h00, 8'h00, 4'd10},
    {1'b1, 3'd1, 8'h0C, 8'h00, 4'd10}, {1'b0, 3'd1, 8'h00, 8'h0C, 4'd10},
    {1'b1, 3'd5, 8'hCC, 8'h00, 4'd7},  {1'b0, 3'd5, 8'h00, 8'hCF, 4'd7},
    {1'b1, 3'd5, 8'h00, 8'h00, 4'd7},  {1'b0, 3'd5, 8'h00, 8'h03, 4'd7},
    {1'b1, 3'd6, 8'hAA, 8'h00, 4'd11}, {1'b0, 3'd6, 8'h00, 8'h00, 4'd11},
    {1'b1, 3'd0, 8'h01, 8'h00, 4'd9},  {1'b0, 3'd0, 8'h00, 8'h01, 4'd9},
    {1'b1, 3'd0, 8'h00, 8'h00, 4'd9}
  };

  always @(negedge clk) begin
    cyc++;
    if (!camRdN || !camWrN) begin
      lowCnt++; seenCe = camCeN; seenIo = camIoSel; seenOe = camDataOe;
      seenAddr = camAddr; seenDout = camDataOut;
    end
    if (camRst[0]) rst0Cnt++;
    if (camRst[1]) rst1Cnt++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic we, input logic [2:0] a, input logic [7:0] d,
                      output logic [7:0] r);
    int t = 0;
    @(negedge clk);
    hostReq = 1; hostWe = we; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostReq = 0;
    while (!hostAck && t < 2000) begin @(negedge clk); t++; end
    if (!hostAck) chk("R11 ack timeout", 0, 1);
    r = hostRdata;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 camRst", camRst, 2'b00);
    chk("R1 tunerRstN", tunerRstN, 2'b11);
    chk("R1 tsOutEn/tsRouteEn", {tsOutEn, tsRouteEn}, 4'b0000);
    chk("R1 irq/busy", {irqOut, hostBusy}, 2'b00);
    chk("R1 bus idle", {camCeN, camRdN, camWrN}, 4'b1111);
    doOp(0, 3'd1, 0, q); chk("R1 ctrl2 reset", q, 8'h0C);
    doOp(0, 3'd2, 0, q); chk("R1 addrLo reset", q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      doOp(VEC[i][23], VEC[i][22:20], VEC[i][19:12], q);
      if (!VEC[i][23]) begin
        checks++;
        if (q !== VEC[i][11:4]) begin
          fails++;
          $display("FAIL vector %0d R%0d: got %h expected %h", i, VEC[i][3:0], q, VEC[i][11:4]);
        end
      end
    end

    // R7 stream routing, R10 second control
    doOp(1, 3'd5, 8'h08, q); @(negedge clk); chk("R7 tsRouteEn", tsRouteEn, 2'b01);
    doOp(1, 3'd1, 8'h10, q); @(negedge clk);
    chk("R10 tsOutEn", tsOutEn, 2'b01); chk("R10 tunerRstN low", tunerRstN, 2'b00);
    doOp(1, 3'd1, 8'h0C, q); @(negedge clk); chk("R10 tunerRstN high", tunerRstN, 2'b11);

    // R3 R5 R2 read access, slot 1, I/O space
    doOp(1, 3'd2, 8'h5A, q); doOp(1, 3'd3, 8'h33, q);
    doOp(1, 3'd5, 8'hC0, q);
    camDataIn = 8'hA5; lowCnt = 0;
    doOp(0, 3'd4, 0, q);
    chk("R5 read data", q, 8'hA5);
    chk("R4 strobe length read", lowCnt, SC + 1);
    chk("R3 ce slot1", seenCe, 2'b01);
    chk("R3 io space", seenIo, 1'b1);
    chk("R2 camAddr", seenAddr, 15'h335A);
    chk("R5 no drive on read", seenOe, 1'b0);

    // R4 write access, slot 0, attribute memory
    doOp(1, 3'd5, 8'h00, q); lowCnt = 0;
    doOp(1, 3'd4, 8'h3C, q);
    chk("R4 write data", seenDout, 8'h3C);
    chk("R4 oe", seenOe, 1'b1);
    chk("R3 ce slot0", seenCe, 2'b10);
    chk("R3 attr space", seenIo, 1'b0);
    chk("R4 strobe length write", lowCnt, SC + 1);

    // R12 wait on ready, R11 busy lockout
    camRdy = 2'b00; lowCnt = 0;
    fork
      doOp(1, 3'd4, 8'h77, q);
      begin
        repeat (6) @(negedge clk);
        chk("R11 busy", hostBusy, 1'b1);
        chk("R12 no ack while not ready", hostAck, 1'b0);
        hostReq = 1; hostWe = 1; hostAddr = 3'd2; hostWdata = 8'h00;
        @(negedge clk); hostReq = 0;
        repeat (6) @(negedge clk);
        camRdy = 2'b11;
      end
    join
    chk("R12 strobe extended", lowCnt > SC + 1, 1);
    doOp(0, 3'd2, 0, q); chk("R11 ignored while busy", q, 8'h5A);

    // R6 slot 0 reset, write 0 mid-pulse does not abort
    camRdy = 2'b10; rst0Cnt = 0;
    doOp(1, 3'd5, 8'h20, q);
    repeat (5) @(negedge clk);
    doOp(1, 3'd5, 8'h00, q);
    repeat (RC + 5) @(negedge clk);
    chk("R6 slot0 pulse length", rst0Cnt, RC);
    doOp(0, 3'd5, 0, q); chk("R6 bit held until ready", q, 8'h23);
    camRdy = 2'b11; repeat (3) @(negedge clk);
    doOp(0, 3'd5, 0, q); chk("R6 bit self clears", q, 8'h03);
    // R6 slot 1
    rst1Cnt = 0;
    doOp(1, 3'd5, 8'h10, q);
    repeat (RC + 5) @(negedge clk);
    chk("R6 slot1 pulse length", rst1Cnt, RC);
    chk("R6 slot0 untouched", rst0Cnt, RC);
    doOp(0, 3'd5, 0, q); chk("R6 slot1 bit clears", q, 8'h03);

    // R8 presence and R9 interrupt
    doOp(1, 3'd0, 8'h01, q);
    camDetN = 2'b10;
    repeat (2) @(negedge clk);
    chk("R9 irq raised", irqOut, 1'b1);
    doOp(0, 3'd5, 0, q); chk("R8 presence bits", q, 8'h01);
    doOp(0, 3'd0, 0, q); chk("R9 pending read", q, 8'h03);
    doOp(0, 3'd0, 0, q); chk("R9 pending cleared", q, 8'h01);
    chk("R9 irqOut cleared", irqOut, 1'b0);
    doOp(1, 3'd0, 8'h00, q);
    camDetN = 2'b01;
    repeat (3) @(negedge clk);
    chk("R9 disabled no irq", irqOut, 1'b0);
    doOp(0, 3'd0, 0, q); chk("R9 disabled pending", q, 8'h00);
    doOp(0, 3'd5, 0, q); chk("R8 slot1 present", q, 8'h02);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule